// File: doc/BRIEF.md
# DMA Bus Request and Transfer Sequencer

This block runs the bus side of a direct-memory-access channel. When its channel request input becomes active, it raises a hold request to the processor. It waits until the processor returns hold acknowledge and only then takes the bus. For each byte it steps through a fixed sequence: an address phase, a strobe phase and a release phase. During the strobe phase it drives a memory strobe and an I/O strobe at the same time, and the transfer direction decides which pair is used. A low READY stretches the strobe phase with wait states.

A companion address/count unit advances once per byte on a one-cycle step pulse and reports the last byte on a terminal-count input. The run also ends when the active-low end-of-process input is pulled low from outside. When the run ends on terminal count, the block drives its own end-of-process output low for one cycle. Two polarity inputs set the active level of the request input and of the acknowledge output. A mode input chooses between single transfers, where the bus is handed back after every byte, and demand transfers, where the bus is kept for as long as the request stays active.

Top module: `dma_xfer_seq`

## Requirements
- R1: From idle, an active request raises `hrq` on the next clock. `aen` stays low for as long as `hlda` is sampled low. The address phase (`aen` high, strobes low) starts one clock after `hlda` is first sampled high.
- R2: `req_pol`=1 makes `dreq` active-high. `req_pol`=0 makes it active-low. An inactive `dreq` leaves `hrq` low.
- R3: `dack` equals `ack_pol` during the address, strobe and release phases. In every other cycle it equals the inverse of `ack_pol`.
- R4: With `dir_rd`=1 (memory to I/O), the strobe phase drives `mem_rd` and `io_wr` high together, and `mem_wr` and `io_rd` stay low.
- R5: With `dir_rd`=0 (I/O to memory), the strobe phase drives `mem_wr` and `io_rd` high together, and `mem_rd` and `io_wr` stay low.
- R6: While `ready` is sampled low, the strobe phase continues with its strobes held. The release phase follows one clock after `ready` is sampled high.
- R7: `aen` is high in every address, strobe and release cycle and low otherwise. Strobes are never high in the address or release phase.
- R8: If `tc_in` is high on the edge that ends the strobe phase, the release cycle drives `eop_out_n` low for exactly that cycle. `hrq` then drops and stays low until the request has gone inactive.
- R9: If `eop_in_n` is sampled low during an address or strobe phase, the run ends after that byte's release: `hrq` drops and `eop_out_n` stays high.
- R10: With `single_mode`=1, every release that does not end the run is followed by one idle cycle with `hrq` low. The block then requests again if the request is still active.
- R11: With `single_mode`=0, a release that does not end the run goes straight to the next address phase while the request is active, with `hrq` held high. If the request is inactive, the block returns to idle.
- R12: `step` is high for exactly the release cycle of each byte, one pulse per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pol | input | 1 | 1: dreq active-high, 0: active-low |
| ack_pol | input | 1 | Active level of dack |
| dir_rd | input | 1 | 1: memory to I/O, 0: I/O to memory |
| single_mode | input | 1 | 1: release bus after every byte |
| dreq | input | 1 | Channel request |
| hlda | input | 1 | Hold acknowledge from processor |
| ready | input | 1 | Low inserts wait states |
| tc_in | input | 1 | Terminal count from address/count unit |
| eop_in_n | input | 1 | External end-of-process, active low |
| hrq | output | 1 | Hold request to processor |
| aen | output | 1 | Bus owned, address enable |
| dack | output | 1 | Channel acknowledge, programmable level |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| eop_out_n | output | 1 | End-of-process pulse on terminal count, active low |
| step | output | 1 | Advance pulse to address/count unit |

## Verification
The assertions assume that `dreq`, `hlda`, `ready`, `tc_in` and `eop_in_n` are synchronous to `clk`. They also assume that the polarity, direction and mode inputs stay stable throughout a run. The stimulus changes the inputs only on falling edges. It reprograms polarity, direction and mode only while the block is idle and the request is inactive. It raises `tc_in` or lowers `eop_in_n` only on the final strobe cycle of a run. Random runs vary the byte count, the wait-state count, the acknowledge delay, both polarities, the direction and the mode. Directed runs cover an inactive request level, a request dropped between demand-mode bytes, and both ways a run can end.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_HOLD = 3'd1,
    S_ADDR = 3'd2,
    S_STRB = 3'd3,
    S_REL  = 3'd4,
    S_DONE = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dma_pol_in.sv
module dma_pol_in #(
  parameter int W = 2
) (
  input  logic [W-1:0] raw,
  input  logic [W-1:0] act_high,
  output logic [W-1:0] asserted
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign asserted[i] = act_high[i] ? raw[i] : ~raw[i];
  end
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_act,
  input  logic       hlda,
  input  logic       ready,
  input  logic       tc,
  input  logic       eop_ext,
  input  logic       single_mode,
  output seq_state_e state,
  output logic       term_tc
);
  seq_state_e state_nx;
  logic       eop_seen, eop_seen_nx;
  logic       term_nx;
  logic       run_end;

  assign run_end = term_tc | eop_seen;

  always_comb begin
    state_nx    = state;
    eop_seen_nx = eop_seen;
    term_nx     = term_tc;
    unique case (state)
      S_IDLE: if (req_act) state_nx = S_HOLD;
      S_HOLD: if (hlda) state_nx = S_ADDR;
      S_ADDR: begin
        state_nx = S_STRB;
        if (eop_ext) eop_seen_nx = 1'b1;
      end
      S_STRB: begin
        if (eop_ext) eop_seen_nx = 1'b1;
        if (ready) begin
          state_nx = S_REL;
          term_nx  = tc;
        end
      end
      S_REL: begin
        eop_seen_nx = 1'b0;
        term_nx     = 1'b0;
        if (run_end) state_nx = S_DONE;
        else if (single_mode || !req_act) state_nx = S_IDLE;
        else state_nx = S_ADDR;
      end
      S_DONE: if (!req_act) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      eop_seen <= 1'b0;
      term_tc  <= 1'b0;
    end else begin
      state    <= state_nx;
      eop_seen <= eop_seen_nx;
      term_tc  <= term_nx;
    end
  end

  // R1: bus phases wait for hold acknowledge
  p_wait_hlda_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && !hlda) |=> (state == S_HOLD));
  // R6: low ready keeps the strobe phase
  p_wait_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STRB && !ready) |=> (state == S_STRB));
  // R8: after terminal count no re-request while request stays active
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && req_act) |=> (state == S_DONE));
endmodule

// File: rtl/dma_bus_drv.sv
module dma_bus_drv
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state,
  input  logic       term_tc,
  input  logic       dir_rd,
  input  logic       ack_pol,
  output logic       hrq,
  output logic       aen,
  output logic       dack,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       io_rd,
  output logic       io_wr,
  output logic       eop_out_n,
  output logic       step
);
  logic own_bus;
  logic strobe;

  assign own_bus   = (state == S_ADDR) || (state == S_STRB) || (state == S_REL);
  assign strobe    = (state == S_STRB);
  assign hrq       = (state != S_IDLE) && (state != S_DONE);
  assign aen       = own_bus;
  assign dack      = ack_pol ? own_bus : ~own_bus;
  assign mem_rd    = strobe & dir_rd;
  assign io_wr     = strobe & dir_rd;
  assign mem_wr    = strobe & ~dir_rd;
  assign io_rd     = strobe & ~dir_rd;
  assign step      = (state == S_REL);
  assign eop_out_n = ~((state == S_REL) & term_tc);

  // R4: memory-read pairs with I/O-write
  p_pair_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (io_wr && !mem_wr && !io_rd));
  // R5: memory-write pairs with I/O-read
  p_pair_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (io_rd && !mem_rd && !io_wr));
  // R7: strobes only while the bus is owned and held
  p_strobe_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (aen && hrq));
  // R8: end-of-process output is a single-cycle pulse
  p_eop_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_out_n |=> eop_out_n);
  // R12: one step per byte
  p_step_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_pol,
  input  logic ack_pol,
  input  logic dir_rd,
  input  logic single_mode,
  input  logic dreq,
  input  logic hlda,
  input  logic ready,
  input  logic tc_in,
  input  logic eop_in_n,
  output logic hrq,
  output logic aen,
  output logic dack,
  output logic mem_rd,
  output logic mem_wr,
  output logic io_rd,
  output logic io_wr,
  output logic eop_out_n,
  output logic step
);
  localparam int NIN = 2;

  logic [NIN-1:0] in_act;
  seq_state_e     state;
  logic           term_tc;

  dma_pol_in #(.W(NIN)) u_pol (
    .raw      ({eop_in_n, dreq}),
    .act_high ({1'b0, req_pol}),
    .asserted (in_act)
  );

  dma_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_act     (in_act[0]),
    .hlda        (hlda),
    .ready       (ready),
    .tc          (tc_in),
    .eop_ext     (in_act[1]),
    .single_mode (single_mode),
    .state       (state),
    .term_tc     (term_tc)
  );

  dma_bus_drv u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .term_tc   (term_tc),
    .dir_rd    (dir_rd),
    .ack_pol   (ack_pol),
    .hrq       (hrq),
    .aen       (aen),
    .dack      (dack),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .eop_out_n (eop_out_n),
    .step      (step)
  );
endmodule

// File: tb/test_dma_xfer_seq.sv
module test_dma_xfer_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic req_pol, ack_pol, dir_rd, single_mode;
  logic dreq, hlda, ready, tc_in, eop_in_n;
  logic hrq, aen, dack, mem_rd, mem_wr, io_rd, io_wr, eop_out_n, step;

  int n_chk = 0;
  int n_err = 0;
  int seed  = 1234;

  always #10 clk = ~clk;

  dma_xfer_seq i_dma_xfer_seq (
    .clk(clk), .rst_n(rst_n), .req_pol(req_pol), .ack_pol(ack_pol),
    .dir_rd(dir_rd), .single_mode(single_mode), .dreq(dreq), .hlda(hlda),
    .ready(ready), .tc_in(tc_in), .eop_in_n(eop_in_n), .hrq(hrq), .aen(aen),
    .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .eop_out_n(eop_out_n), .step(step)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected strobe bundle {mem_rd,mem_wr,io_rd,io_wr}
  function automatic logic [3:0] exp_strb(input logic on, input logic rd);
    if (!on) return 4'b0000;
    return rd ? 4'b1001 : 4'b0110;
  endfunction

  function automatic logic [3:0] strb_now();
    return {mem_rd, mem_wr, io_rd, io_wr};
  endfunction

  // dack level for a given phase ownership
  function automatic logic exp_ack(input logic own, input logic ap);
    return own ? ap : ~ap;
  endfunction

  task automatic check_addr(input logic ap);
    check("R7 aen in address", {31'd0, aen}, 32'd1);
    check("R3 dack in address", {31'd0, dack}, {31'd0, exp_ack(1'b1, ap)});
    check("R7 no strobe in address", {28'd0, strb_now()}, 32'd0);
  endtask

  // one run: end_kind 0 = terminal count, 1 = external eop;
  // drop_b >= 0: drop request at release of byte drop_b (demand mode)
  task automatic run(input logic rp, input logic ap, input logic rd, input logic sm,
                     input int nbytes, input int maxw, input int end_kind,
                     input int hdly, input int drop_b);
    int steps = 0;
    req_pol = rp; ack_pol = ap; dir_rd = rd; single_mode = sm;
    dreq = ~rp; hlda = 1'b0; ready = 1'b0; tc_in = 1'b0; eop_in_n = 1'b1;
    @(negedge clk);
    check("R3 dack idle", {31'd0, dack}, {31'd0, exp_ack(1'b0, ap)});
    check("R2 idle no request", {31'd0, hrq}, 32'd0);
    dreq = rp;
    @(negedge clk);
    check("R1 hrq after request", {31'd0, hrq}, 32'd1);
    check("R1 aen low before hlda", {31'd0, aen}, 32'd0);
    for (int k = 0; k < hdly; k++) begin
      @(negedge clk);
      check("R1 waiting for hlda", {30'd0, hrq, aen}, 32'd2);
    end
    hlda = 1'b1;
    @(negedge clk);
    check_addr(ap);
    for (int b = 0; b < nbytes; b++) begin
      logic last;
      int w;
      last = (b == nbytes - 1);
      w = $urandom_range(maxw, 0);
      @(negedge clk);
      check(rd ? "R4 read strobes" : "R5 write strobes", {28'd0, strb_now()},
            {28'd0, exp_strb(1'b1, rd)});
      check("R3 dack in strobe", {31'd0, dack}, {31'd0, ap});
      for (int i = 0; i < w; i++) begin
        @(negedge clk);
        check("R6 wait holds strobes", {28'd0, strb_now()}, {28'd0, exp_strb(1'b1, rd)});
        check("R12 no step in wait", {31'd0, step}, 32'd0);
      end
      ready = 1'b1;
      if (last && end_kind == 0) tc_in = 1'b1;
      if (last && end_kind == 1) eop_in_n = 1'b0;
      @(negedge clk);
      check("R12 step in release", {31'd0, step}, 32'd1);
      check("R7 release owns bus", {27'd0, aen, strb_now()}, 32'h10);
      check("R3 dack in release", {31'd0, dack}, {31'd0, ap});
      check(end_kind == 0 ? "R8 eop pulse" : "R9 no eop pulse", {31'd0, eop_out_n},
            {31'd0, !(last && end_kind == 0)});
      steps++;
      ready = 1'b0; tc_in = 1'b0; eop_in_n = 1'b1;
      if (!last && !sm && b == drop_b) begin
        dreq = ~rp;
        @(negedge clk);
        check("R11 idle after dropped request", {30'd0, hrq, aen}, 32'd0);
        hlda = 1'b0;
        @(negedge clk);
        check("R11 stays idle", {31'd0, hrq}, 32'd0);
        check("R12 step count", steps, b + 1);
        return;
      end
      if (last) begin
        @(negedge clk);
        check(end_kind == 0 ? "R8 hrq drops" : "R9 hrq drops", {30'd0, hrq, aen}, 32'd0);
        check("R8 eop released", {31'd0, eop_out_n}, 32'd1);
        @(negedge clk);
        check(end_kind == 0 ? "R8 no re-request" : "R9 no re-request", {31'd0, hrq}, 32'd0);
        dreq = ~rp; hlda = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 inactive after run", {31'd0, hrq}, 32'd0);
      end else if (sm) begin
        @(negedge clk);
        check("R10 idle gap", {30'd0, hrq, aen}, 32'd0);
        @(negedge clk);
        check("R10 re-request", {30'd0, hrq, aen}, 32'd2);
        @(negedge clk);
        check_addr(ap);
      end else begin
        @(negedge clk);
        check("R11 hrq held", {31'd0, hrq}, 32'd1);
        check_addr(ap);
      end
    end
    check("R12 step count", steps, nbytes);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(seed));
    rst_n = 1'b0;
    req_pol = 1'b1; ack_pol = 1'b0; dir_rd = 1'b1; single_mode = 1'b0;
    dreq = 1'b0; hlda = 1'b0; ready = 1'b0; tc_in = 1'b0; eop_in_n = 1'b1;
    @(negedge clk);
    check("R7 reset aen", {31'd0, aen}, 32'd0);
    check("R1 reset hrq", {31'd0, hrq}, 32'd0);
    check("R3 reset dack", {31'd0, dack}, 32'd1);
    check("R12 reset step", {31'd0, step}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: active-low request, line held high, must not request
    req_pol = 1'b0; dreq = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 high level inactive when active-low", {31'd0, hrq}, 32'd0);
    // directed corners
    run(1'b1, 1'b1, 1'b1, 1'b0, 1, 0, 0, 0, -1);
    run(1'b0, 1'b0, 1'b0, 1'b1, 3, 2, 0, 2, -1);
    run(1'b1, 1'b0, 1'b1, 1'b0, 4, 1, 1, 1, -1);
    run(1'b0, 1'b1, 1'b0, 1'b0, 5, 0, 0, 0, 1);
    run(1'b1, 1'b1, 1'b0, 1'b1, 2, 3, 1, 3, -1);
    // random runs
    for (int n = 0; n < 40; n++) begin
      run($urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0),
          $urandom_range(1, 0), $urandom_range(6, 1), $urandom_range(3, 0),
          $urandom_range(1, 0), $urandom_range(3, 0), -1);
    end
    report();
  end
endmodule